// File: doc/BRIEF.md
# Page Mapping Table Programmer

This block fills an address-translation table, one entry per virtual page. Each entry gives the external physical page and the memory that backs it. A command names the backing memory, a virtual start address, a physical start address, a page size in kilobytes, a page count and a fixed flag.

The block first validates the arguments and settles on one result code. On success it writes one table entry per page through a table write port. With the fixed flag clear, the physical page advances with the virtual page. With the flag set, every virtual page in the run points at the same physical page.

A separate init command clears the whole table. It writes the invalid-page marker and the invalid target into every entry. The translation lookup itself and any data movement belong to other blocks.

Top module: `pgmap_prog`

## Requirements
- R1: After reset, `busy`, `done` and `tblWe` are 0 and `errCode` is 0.
- R2: A page size other than 64 (KB) gives `errCode` 3. This check comes before all others, and nothing is written.
- R3: A virtual or physical address with any of its low 16 bits set gives `errCode` 2. This check takes precedence over the range check, and nothing is written.
- R4: The command gives `errCode` 4 and writes nothing in either of two cases:
  - the virtual address is below `WIN_BASE`;
  - the first page index, `(vaddr-WIN_BASE)>>16`, plus the count exceeds `NUM_ENTRIES`.
- R5: An accepted valid command writes `cmdCount` entries, one per cycle, starting the cycle after acceptance. Indices run upward from the first page index, and `busy` is high exactly during these writes.
- R6: With `cmdFixed` 0, entry k gets physical page `(paddr>>16)+k`. Every entry gets `cmdTarget` (0 invalid, 1 flash, 2 external RAM).
- R7: With `cmdFixed` 1, every entry in the run gets physical page `paddr>>16`.
- R8: An init command writes all `NUM_ENTRIES` entries, indices 0 upward. Each gets page 0xFFFF and target 0, and the result code is 0.
- R9: A valid command with a page count of 0 gives `done` the next cycle with code 0 and writes nothing.
- R10: A command presented while `busy` is high is ignored.
- R11: `done` pulses for one cycle after the last write, or the cycle after acceptance when nothing is written. `errCode` holds its value until the next accepted command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cmdValid | input | 1 | Command strobe, taken when not busy |
| cmdInit | input | 1 | Selects the table-clear command |
| cmdTarget | input | 2 | Backing memory: 0 invalid, 1 flash, 2 external RAM |
| cmdVaddr | input | 32 | Virtual start address |
| cmdPaddr | input | 32 | Physical start address |
| cmdSizeKb | input | 16 | Page size in KB |
| cmdCount | input | 16 | Number of pages |
| cmdFixed | input | 1 | All pages map to one physical page |
| busy | output | 1 | Entries are being written |
| done | output | 1 | One-cycle completion pulse |
| errCode | output | 3 | Result code of the last command |
| tblWe | output | 1 | Table write enable |
| tblIdx | output | 6 | Table entry index |
| tblPage | output | 16 | Physical page written |
| tblTarget | output | 2 | Target selector written |

## Verification
The main function is tried with three kinds of command:
- A run with consecutive pages tells the incrementing physical page apart from a stuck one.
- A fixed run tells a held page apart from an advancing one.
- A run ending exactly at the last entry is set against one a page longer. This separates an off-by-one range check from a correct one.

Commands that fail two checks at once show whether the code follows the stated priority. An init command and a command injected while busy show that the whole table is cleared and that a running sequence cannot be restarted.

// File: rtl/pgmap_pkg.sv
package pgmap_pkg;
  localparam logic [2:0] ERR_OK    = 3'd0;
  localparam logic [2:0] ERR_ALIGN = 3'd2;
  localparam logic [2:0] ERR_SIZE  = 3'd3;
  localparam logic [2:0] ERR_RANGE = 3'd4;

  localparam logic [1:0] TGT_NONE = 2'd0;

  typedef enum logic {S_IDLE, S_WRITE} ctrlState_t;

  typedef struct packed {
    logic load;
    logic init;
    logic step;
  } dpStrobe_t;
endpackage

// File: rtl/pgmap_argchk.sv
module pgmap_argchk
  import pgmap_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int PAGE_SHIFT  = 16,
  parameter int PAGE_KB     = 64,
  parameter int SIZE_W      = 16,
  parameter int CNT_W       = 16,
  parameter int NUM_ENTRIES = 64,
  parameter int IDX_W       = 6,
  parameter logic [ADDR_W-1:0] WIN_BASE = 32'h4000_0000
) (
  input  logic [ADDR_W-1:0] vaddr,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [SIZE_W-1:0] sizeKb,
  input  logic [CNT_W-1:0]  count,
  output logic [2:0]        chkErr,
  output logic [IDX_W-1:0]  firstIdx
);
  localparam int VP_W = ADDR_W - PAGE_SHIFT;
  localparam int EW   = ((VP_W > CNT_W) ? VP_W : CNT_W) + 1;
  localparam logic [VP_W-1:0] BASE_PAGE = WIN_BASE[ADDR_W-1:PAGE_SHIFT];

  logic [VP_W-1:0] vPage;
  logic [VP_W-1:0] relPage;
  logic [EW-1:0]   endPage;
  logic            sizeBad, alignBad, rangeBad;

  always_comb begin
    vPage    = vaddr[ADDR_W-1:PAGE_SHIFT];
    relPage  = vPage - BASE_PAGE;
    endPage  = EW'(relPage) + EW'(count);
    sizeBad  = (sizeKb != SIZE_W'(PAGE_KB));
    alignBad = (vaddr[PAGE_SHIFT-1:0] != '0) || (paddr[PAGE_SHIFT-1:0] != '0);
    rangeBad = (vPage < BASE_PAGE) || (endPage > EW'(NUM_ENTRIES));
    firstIdx = relPage[IDX_W-1:0];
    if (sizeBad)       chkErr = ERR_SIZE;
    else if (alignBad) chkErr = ERR_ALIGN;
    else if (rangeBad) chkErr = ERR_RANGE;
    else               chkErr = ERR_OK;
  end
endmodule

// File: rtl/pgmap_ctrl.sv
module pgmap_ctrl
  import pgmap_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  input  logic             cmdInit,
  input  logic [CNT_W-1:0] cmdCount,
  input  logic [2:0]       chkErr,
  input  logic             lastEntry,
  output dpStrobe_t        strb,
  output logic             busy,
  output logic             done,
  output logic [2:0]       errCode
);
  ctrlState_t state;
  logic accept, argOk, countZero;

  always_comb begin
    accept    = cmdValid && (state == S_IDLE);
    argOk     = (chkErr == ERR_OK);
    countZero = (cmdCount == '0);
    strb      = '0;
    if (accept) begin
      if (cmdInit) begin
        strb.load = 1'b1;
        strb.init = 1'b1;
      end else if (argOk && !countZero) begin
        strb.load = 1'b1;
      end
    end
    if (state == S_WRITE) strb.step = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      done    <= 1'b0;
      errCode <= ERR_OK;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (accept) begin
          if (cmdInit) begin
            errCode <= ERR_OK;
            state   <= S_WRITE;
          end else if (!argOk) begin
            errCode <= chkErr;
            done    <= 1'b1;
          end else if (countZero) begin
            errCode <= ERR_OK;
            done    <= 1'b1;
          end else begin
            errCode <= ERR_OK;
            state   <= S_WRITE;
          end
        end
        S_WRITE: if (lastEntry) begin
          state <= S_IDLE;
          done  <= 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy = (state == S_WRITE);
endmodule

// File: rtl/pgmap_dp.sv
module pgmap_dp
  import pgmap_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int IDX_W       = 6,
  parameter int PP_W        = 16,
  parameter int NUM_ENTRIES = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strb,
  input  logic [IDX_W-1:0] firstIdx,
  input  logic [PP_W-1:0]  firstPage,
  input  logic [1:0]       target,
  input  logic             fixedMap,
  input  logic [CNT_W-1:0] count,
  output logic [IDX_W-1:0] curIdx,
  output logic [PP_W-1:0]  curPage,
  output logic [1:0]       curTarget,
  output logic             lastEntry
);
  logic [CNT_W-1:0] remain;
  logic             holdPage;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curIdx    <= '0;
      curPage   <= '1;
      curTarget <= TGT_NONE;
      holdPage  <= 1'b0;
      remain    <= '0;
    end else if (strb.load) begin
      curIdx    <= strb.init ? '0 : firstIdx;
      curPage   <= strb.init ? '1 : firstPage;
      curTarget <= strb.init ? TGT_NONE : target;
      holdPage  <= strb.init ? 1'b1 : fixedMap;
      remain    <= strb.init ? CNT_W'(NUM_ENTRIES) : count;
    end else if (strb.step) begin
      curIdx  <= curIdx + 1'b1;
      curPage <= holdPage ? curPage : curPage + 1'b1;
      remain  <= remain - 1'b1;
    end
  end

  assign lastEntry = (remain == CNT_W'(1));
endmodule

// File: rtl/pgmap_prog.sv
module pgmap_prog
  import pgmap_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int PAGE_KB     = 64,
  parameter int SIZE_W      = 16,
  parameter int CNT_W       = 16,
  parameter int NUM_ENTRIES = 64,
  parameter logic [ADDR_W-1:0] WIN_BASE = 32'h4000_0000,
  localparam int PAGE_SHIFT = $clog2(PAGE_KB * 1024),
  localparam int PP_W       = ADDR_W - PAGE_SHIFT,
  localparam int IDX_W      = $clog2(NUM_ENTRIES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic              cmdInit,
  input  logic [1:0]        cmdTarget,
  input  logic [ADDR_W-1:0] cmdVaddr,
  input  logic [ADDR_W-1:0] cmdPaddr,
  input  logic [SIZE_W-1:0] cmdSizeKb,
  input  logic [CNT_W-1:0]  cmdCount,
  input  logic              cmdFixed,
  output logic              busy,
  output logic              done,
  output logic [2:0]        errCode,
  output logic              tblWe,
  output logic [IDX_W-1:0]  tblIdx,
  output logic [PP_W-1:0]   tblPage,
  output logic [1:0]        tblTarget
);
  logic [2:0]       chkErr;
  logic [IDX_W-1:0] firstIdx;
  logic             lastEntry;
  dpStrobe_t        strb;

  pgmap_argchk #(
    .ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT), .PAGE_KB(PAGE_KB),
    .SIZE_W(SIZE_W), .CNT_W(CNT_W), .NUM_ENTRIES(NUM_ENTRIES),
    .IDX_W(IDX_W), .WIN_BASE(WIN_BASE)
  ) chk_i (
    .vaddr(cmdVaddr), .paddr(cmdPaddr), .sizeKb(cmdSizeKb),
    .count(cmdCount), .chkErr(chkErr), .firstIdx(firstIdx)
  );

  pgmap_ctrl #(.CNT_W(CNT_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdInit(cmdInit),
    .cmdCount(cmdCount), .chkErr(chkErr), .lastEntry(lastEntry),
    .strb(strb), .busy(busy), .done(done), .errCode(errCode)
  );

  pgmap_dp #(
    .CNT_W(CNT_W), .IDX_W(IDX_W), .PP_W(PP_W), .NUM_ENTRIES(NUM_ENTRIES)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .firstIdx(firstIdx),
    .firstPage(cmdPaddr[ADDR_W-1:PAGE_SHIFT]), .target(cmdTarget),
    .fixedMap(cmdFixed), .count(cmdCount), .curIdx(tblIdx),
    .curPage(tblPage), .curTarget(tblTarget), .lastEntry(lastEntry)
  );

  assign tblWe = strb.step;
endmodule

// File: rtl/pgmap_prog_chk.sv
module pgmap_prog_chk #(
  parameter int IDX_W = 6
) (
  input logic             clk,
  input logic             rstN,
  input logic             cmdValid,
  input logic             busy,
  input logic             done,
  input logic [2:0]       errCode,
  input logic             tblWe,
  input logic [IDX_W-1:0] tblIdx,
  input logic [1:0]       tblTarget
);
  p_we_matches_busy_r5: assert property (@(posedge clk) disable iff (!rstN)
    tblWe == busy);
  p_start_needs_cmd_r10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(cmdValid));
  p_idx_ascends_r5: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> tblIdx == IDX_W'($past(tblIdx) + 1'b1));
  p_target_stable_r6: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(tblTarget));
  p_done_idle_r11: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);
  p_end_ok_r11: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (done && errCode == 3'd0));
  p_code_legal_r2: assert property (@(posedge clk) disable iff (!rstN)
    errCode inside {3'd0, 3'd2, 3'd3, 3'd4});
endmodule

bind pgmap_prog pgmap_prog_chk #(.IDX_W(IDX_W)) chk_bind_i (
  .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .busy(busy), .done(done),
  .errCode(errCode), .tblWe(tblWe), .tblIdx(tblIdx), .tblTarget(tblTarget)
);

// File: tb/pgmap_prog_tb_top.sv
module pgmap_prog_tb_top;
  localparam logic [31:0] BASE = 32'h4000_0000;
  localparam int NENT = 64;
  localparam logic [31:0] PG = 32'h0001_0000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0, cmdInit = 1'b0, cmdFixed = 1'b0;
  logic [1:0]  cmdTarget = 2'd0;
  logic [31:0] cmdVaddr = '0, cmdPaddr = '0;
  logic [15:0] cmdSizeKb = 16'd64, cmdCount = '0;
  logic        busy, done, tblWe;
  logic [2:0]  errCode;
  logic [5:0]  tblIdx;
  logic [15:0] tblPage;
  logic [1:0]  tblTarget;

  int errors = 0, checks = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  pgmap_prog dut_i (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdInit(cmdInit),
    .cmdTarget(cmdTarget), .cmdVaddr(cmdVaddr), .cmdPaddr(cmdPaddr),
    .cmdSizeKb(cmdSizeKb), .cmdCount(cmdCount), .cmdFixed(cmdFixed),
    .busy(busy), .done(done), .errCode(errCode), .tblWe(tblWe),
    .tblIdx(tblIdx), .tblPage(tblPage), .tblTarget(tblTarget)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic issue(input bit init, input logic [1:0] tgt, input logic [31:0] va,
                       input logic [31:0] pa, input logic [15:0] sz,
                       input logic [15:0] cnt, input bit fx);
    cmdInit = init; cmdTarget = tgt; cmdVaddr = va; cmdPaddr = pa;
    cmdSizeKb = sz; cmdCount = cnt; cmdFixed = fx; cmdValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  // Successful run: R5, R6, R7, optionally R10 injection
  task automatic runOk(input string tag, input logic [1:0] tgt, input logic [31:0] va,
                       input logic [31:0] pa, input int cnt, input bit fx, input bit inject);
    logic [5:0]  idx0;
    logic [15:0] pg0;
    idx0 = 6'((va - BASE) >> 16);
    pg0  = pa[31:16];
    issue(1'b0, tgt, va, pa, 16'd64, 16'(cnt), fx);
    for (int k = 0; k < cnt; k++) begin
      chk(tblWe && busy, {tag, " R5 write active"}, {30'd0, busy, tblWe}, 32'h3);
      chk(tblIdx == 6'(idx0 + k), {tag, " R5 index"}, tblIdx, 6'(idx0 + k));
      if (fx) chk(tblPage == pg0, {tag, " R7 fixed page"}, tblPage, pg0);
      else    chk(tblPage == 16'(pg0 + k), {tag, " R6 page"}, tblPage, 16'(pg0 + k));
      chk(tblTarget == tgt, {tag, " R6 target"}, tblTarget, tgt);
      if (inject && k == 1) begin
        cmdInit = 1'b1; cmdValid = 1'b1;
      end else begin
        cmdValid = 1'b0; cmdInit = 1'b0;
      end
      @(negedge clk);
    end
    cmdValid = 1'b0; cmdInit = 1'b0;
    chk(done && !busy && !tblWe, {tag, " R11 done after last"}, {29'd0, done, busy, tblWe}, 32'h4);
    chk(errCode == 3'd0, {tag, " R5 code"}, errCode, 0);
    @(negedge clk);
    chk(!done && !tblWe, {tag, " R11 done one cycle / R10 no restart"}, {30'd0, done, tblWe}, 0);
  endtask

  // Failing or empty command: R2, R3, R4, R9, R11
  task automatic runNoWrite(input string tag, input logic [31:0] va, input logic [31:0] pa,
                            input logic [15:0] sz, input logic [15:0] cnt,
                            input logic [2:0] expErr);
    issue(1'b0, 2'd1, va, pa, sz, cnt, 1'b0);
    chk(done && !busy && !tblWe, {tag, " done without write"}, {29'd0, done, busy, tblWe}, 32'h4);
    chk(errCode == expErr, {tag, " code"}, errCode, expErr);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(!tblWe && !busy && !done, {tag, " stays idle"}, {29'd0, done, busy, tblWe}, 0);
    end
    chk(errCode == expErr, {tag, " R11 code held"}, errCode, expErr);
  endtask

  task automatic runInit();
    issue(1'b1, 2'd2, BASE, 32'h0005_0000, 16'd7, 16'd3, 1'b0);
    for (int k = 0; k < NENT; k++) begin
      chk(tblWe, "R8 init write", tblWe, 1);
      chk(tblIdx == 6'(k), "R8 init index", tblIdx, k);
      chk(tblPage == 16'hFFFF && tblTarget == 2'd0, "R8 init entry",
          {14'd0, tblTarget, tblPage}, 32'hFFFF);
      @(negedge clk);
    end
    chk(done && !tblWe && errCode == 3'd0, "R8 init done", {28'd0, done, errCode}, 32'h8);
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !tblWe && errCode == 3'd0, "R1 reset state",
        {27'd0, busy, done, tblWe, errCode[1:0]}, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !tblWe, "R1 after release", {29'd0, busy, done, tblWe}, 0);

    runOk("flash run", 2'd1, BASE + 3 * PG, 32'h0012_0000, 5, 1'b0, 1'b0);
    runOk("fixed run", 2'd2, BASE + 10 * PG, 32'h0007_0000, 4, 1'b1, 1'b0);
    runOk("edge fit", 2'd1, BASE + 62 * PG, 32'h00FF_0000, 2, 1'b0, 1'b0);
    runNoWrite("R2 bad size", BASE + 1, 32'h0001_0000, 16'd32, 16'd2, 3'd3);
    runNoWrite("R2 size before range", BASE - PG, 32'h0, 16'd128, 16'd1, 3'd3);
    runNoWrite("R3 paddr misaligned", BASE, 32'h0001_8000, 16'd64, 16'd1, 3'd2);
    runNoWrite("R3 align before range", 32'h1000_0100, 32'h0, 16'd64, 16'd1, 3'd2);
    runNoWrite("R4 below window", BASE - PG, 32'h0, 16'd64, 16'd1, 3'd4);
    runNoWrite("R4 past end", BASE + 62 * PG, 32'h0, 16'd64, 16'd3, 3'd4);
    runNoWrite("R9 zero count", BASE + 5 * PG, 32'h0003_0000, 16'd64, 16'd0, 3'd0);
    runOk("R10 busy inject", 2'd1, BASE + 20 * PG, 32'h0040_0000, 4, 1'b0, 1'b1);
    runInit();

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule